// File: doc/BRIEF.md
# Configurable Macrocell Storage Element

This block is the output stage of one programmable-logic macrocell. A single storage bit can act as a D flip-flop, a toggle flip-flop or a level-sensitive latch. Configuration inputs select the clock source, the reset source, the preset source, the data path and the output-enable source for the pin driver. The stored value appears on the macrocell output and on a feedback output for the internal interconnect. The feedback output is valid even when the pin is not driven, which is the buried case.

The clock sources are treated as level signals sampled by the system clock `clk_i`. A rising level on the selected source acts as the storage clock edge. Reset and preset bypass the register and act on the outputs at once. They also force the stored bit on the next system clock. The configuration is held static while the block runs. After `rst_ni` the stored bit is 0.

Top module: `mcell_store`

## Requirements
- R1: In D mode (mode code 0, and code 3 also behaves as D), a rising level on the selected clock source with `clken_i` high loads the selected data into the stored bit. Without that edge, or with `clken_i` low, the bit holds.
- R2: In T mode (mode code 1), a rising level on the selected clock source with `clken_i` high inverts the stored bit when the selected data is 1. When the data is 0 the bit holds.
- R3: In latch mode (mode code 2), `q_o` follows the selected data combinationally while the selected clock source is high. When the source goes low, `q_o` holds the last value.
- R4: In latch mode, `clken_i` has no effect.
- R5: Clock select codes map as follows: 0 to NUM_GCLK-1 pick `gclk_i[code]`, NUM_GCLK picks `uclk_i`, and the next four codes pick `ct_i[4]` to `ct_i[7]`. Any higher code picks no clock. A pulse on a source that is not selected has no effect.
- R6: Data select 0 takes `lterm_i`. Data select 1 takes `pad_i` directly.
- R7: Reset select code 0 means no reset, code 1 picks `urst_i`, and codes 2 to 7 pick `ct_i[0]` to `ct_i[5]`. An active reset drives `q_o` to 0 at once, without waiting for a clock, and clears the stored bit.
- R8: Preset select uses the same encoding with `upst_i`. An active preset drives `q_o` to 1 at once, and reset wins when both are active.
- R9: `fb_o` always equals `q_o`, whatever the output-enable code.
- R10: `oe_o` by code: 0 gives 0, 1 gives `ct_i[0]`, 2 gives `ct_i[1]`, 3 gives `ct_i[2]`, 4 gives `ct_i[6]`, 5 gives `uoe_i`, 6 gives 1, 7 gives 0.
- R11: `pullup_o` is 1 for output-enable code 7. It is also 1 for code 0 when `cfg_pin_unused_i` is 1. Otherwise it is 0.
- R12: After `rst_ni` is released, `q_o` and `fb_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples all sources |
| rst_ni | input | 1 | Active-low power-up reset |
| cfg_mode_i | input | 2 | Storage mode: 0 D, 1 T, 2 latch, 3 D |
| cfg_clk_sel_i | input | 4 | Clock source code |
| cfg_rst_sel_i | input | 3 | Reset source code |
| cfg_pst_sel_i | input | 3 | Preset source code |
| cfg_din_sel_i | input | 1 | Data source: 0 logic term, 1 pad |
| cfg_oe_sel_i | input | 3 | Output-enable code |
| cfg_pin_unused_i | input | 1 | Pin is unused as an input |
| gclk_i | input | NUM_GCLK | Pin-driven global clocks |
| uclk_i | input | 1 | Shared universal clock |
| urst_i | input | 1 | Shared universal reset |
| upst_i | input | 1 | Shared universal preset |
| uoe_i | input | 1 | Shared universal output enable |
| ct_i | input | 8 | Per-block control terms |
| clken_i | input | 1 | Clock enable |
| lterm_i | input | 1 | Logic-term data |
| pad_i | input | 1 | Pad data for the registered-input path |
| q_o | output | 1 | Macrocell output value |
| fb_o | output | 1 | Feedback copy to the interconnect |
| oe_o | output | 1 | Pin driver enable |
| pullup_o | output | 1 | Weak pull-up request |

## Verification
A wrong stored bit shows on `q_o` and `fb_o` at the first sample after the system clock edge that follows the source pulse. A latch that is not transparent shows within the same cycle, because the output path bypasses the register while the enable is high. A wrong reset or preset priority shows without any clock, because the override acts on the output combinationally. A wrong source decode shows as a missed or spurious update after one pulse on an unselected source.

// File: rtl/mcell_pkg.sv
package mcell_pkg;
    typedef enum logic [1:0] {
        MODE_D     = 2'd0,
        MODE_T     = 2'd1,
        MODE_LATCH = 2'd2,
        MODE_D_ALT = 2'd3
    } mc_mode_e;

    localparam int CT_W      = 8;
    localparam int SET_SEL_W = 3;
    localparam int OE_SEL_W  = 3;
    localparam int CT_CLK_N  = 4;
    localparam int CT_SET_N  = 6;

    typedef struct packed {
        logic state;
        logic clk_prev;
    } core_reg_t;
endpackage

// File: rtl/mcell_clk_sel.sv
module mcell_clk_sel #(
    parameter int NUM_GCLK  = 4,
    parameter int SEL_W     = 4
) (
    input  logic [SEL_W-1:0]                 sel_i,
    input  logic [NUM_GCLK-1:0]              gclk_i,
    input  logic                             uclk_i,
    input  logic [mcell_pkg::CT_CLK_N-1:0]   ctc_i,
    output logic                             clk_lvl_o
);
    localparam int UCLK_CODE = NUM_GCLK;
    localparam int CT_BASE   = NUM_GCLK + 1;

    always_comb begin
        clk_lvl_o = 1'b0;
        for (int i = 0; i < NUM_GCLK; i++) begin
            if (sel_i == SEL_W'(i)) clk_lvl_o = gclk_i[i];
        end
        if (sel_i == SEL_W'(UCLK_CODE)) clk_lvl_o = uclk_i;
        for (int j = 0; j < mcell_pkg::CT_CLK_N; j++) begin
            if (sel_i == SEL_W'(CT_BASE + j)) clk_lvl_o = ctc_i[j];
        end
    end
endmodule

// File: rtl/mcell_set_sel.sv
module mcell_set_sel (
    input  logic [mcell_pkg::SET_SEL_W-1:0] sel_i,
    input  logic                            uni_i,
    input  logic [mcell_pkg::CT_SET_N-1:0]  cts_i,
    output logic                            act_o
);
    localparam int W = mcell_pkg::SET_SEL_W;

    always_comb begin
        act_o = 1'b0;
        if (sel_i == W'(1)) act_o = uni_i;
        for (int j = 0; j < mcell_pkg::CT_SET_N; j++) begin
            if (sel_i == W'(j + 2)) act_o = cts_i[j];
        end
    end
endmodule

// File: rtl/mcell_oe.sv
module mcell_oe (
    input  logic [mcell_pkg::OE_SEL_W-1:0] sel_i,
    input  logic [3:0]                     cto_i,
    input  logic                           uoe_i,
    input  logic                           pin_unused_i,
    output logic                           oe_o,
    output logic                           pullup_o
);
    always_comb begin
        oe_o     = 1'b0;
        pullup_o = 1'b0;
        case (sel_i)
            3'd0: pullup_o = pin_unused_i;
            3'd1: oe_o = cto_i[0];
            3'd2: oe_o = cto_i[1];
            3'd3: oe_o = cto_i[2];
            3'd4: oe_o = cto_i[3];
            3'd5: oe_o = uoe_i;
            3'd6: oe_o = 1'b1;
            default: pullup_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/mcell_core.sv
module mcell_core
    import mcell_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  mc_mode_e mode_i,
    input  logic     clk_lvl_i,
    input  logic     clken_i,
    input  logic     din_i,
    input  logic     rst_act_i,
    input  logic     pst_act_i,
    output logic     q_o,
    output logic     state_o,
    output logic     clk_edge_o
);
    core_reg_t r_d, r_q;
    logic      edge_w;

    always_comb begin
        r_d          = r_q;
        r_d.clk_prev = clk_lvl_i;
        edge_w       = clk_lvl_i & ~r_q.clk_prev;
        case (mode_i)
            MODE_T: begin
                if (edge_w && clken_i && din_i) r_d.state = ~r_q.state;
            end
            MODE_LATCH: begin
                if (clk_lvl_i) r_d.state = din_i;
            end
            default: begin
                if (edge_w && clken_i) r_d.state = din_i;
            end
        endcase
        if (rst_act_i)      r_d.state = 1'b0;
        else if (pst_act_i) r_d.state = 1'b1;

        if (rst_act_i)                            q_o = 1'b0;
        else if (pst_act_i)                       q_o = 1'b1;
        else if (mode_i == MODE_LATCH && clk_lvl_i) q_o = din_i;
        else                                      q_o = r_q.state;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign state_o    = r_q.state;
    assign clk_edge_o = edge_w;
endmodule

// File: rtl/mcell_store.sv
module mcell_store #(
    parameter int NUM_GCLK = 4,
    parameter int CLK_SEL_W = $clog2(NUM_GCLK + 1 + mcell_pkg::CT_CLK_N + 1)
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [1:0]           cfg_mode_i,
    input  logic [CLK_SEL_W-1:0] cfg_clk_sel_i,
    input  logic [2:0]           cfg_rst_sel_i,
    input  logic [2:0]           cfg_pst_sel_i,
    input  logic                 cfg_din_sel_i,
    input  logic [2:0]           cfg_oe_sel_i,
    input  logic                 cfg_pin_unused_i,
    input  logic [NUM_GCLK-1:0]  gclk_i,
    input  logic                 uclk_i,
    input  logic                 urst_i,
    input  logic                 upst_i,
    input  logic                 uoe_i,
    input  logic [7:0]           ct_i,
    input  logic                 clken_i,
    input  logic                 lterm_i,
    input  logic                 pad_i,
    output logic                 q_o,
    output logic                 fb_o,
    output logic                 oe_o,
    output logic                 pullup_o
);
    import mcell_pkg::*;

    logic clk_lvl, clk_edge, din, rst_act, pst_act, state_q;

    assign din = cfg_din_sel_i ? pad_i : lterm_i;

    mcell_clk_sel #(.NUM_GCLK(NUM_GCLK), .SEL_W(CLK_SEL_W)) u_clk_sel (
        .sel_i     (cfg_clk_sel_i),
        .gclk_i    (gclk_i),
        .uclk_i    (uclk_i),
        .ctc_i     (ct_i[7:4]),
        .clk_lvl_o (clk_lvl)
    );

    mcell_set_sel u_rst_sel (
        .sel_i (cfg_rst_sel_i),
        .uni_i (urst_i),
        .cts_i (ct_i[5:0]),
        .act_o (rst_act)
    );

    mcell_set_sel u_pst_sel (
        .sel_i (cfg_pst_sel_i),
        .uni_i (upst_i),
        .cts_i (ct_i[5:0]),
        .act_o (pst_act)
    );

    mcell_core u_core (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .mode_i     (mc_mode_e'(cfg_mode_i)),
        .clk_lvl_i  (clk_lvl),
        .clken_i    (clken_i),
        .din_i      (din),
        .rst_act_i  (rst_act),
        .pst_act_i  (pst_act),
        .q_o        (q_o),
        .state_o    (state_q),
        .clk_edge_o (clk_edge)
    );

    assign fb_o = q_o;

    mcell_oe u_oe (
        .sel_i        (cfg_oe_sel_i),
        .cto_i        ({ct_i[6], ct_i[2:0]}),
        .uoe_i        (uoe_i),
        .pin_unused_i (cfg_pin_unused_i),
        .oe_o         (oe_o),
        .pullup_o     (pullup_o)
    );
endmodule

// File: rtl/mcell_store_chk.sv
module mcell_store_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic [1:0] mode,
    input logic       clk_lvl,
    input logic       clk_edge,
    input logic       clken,
    input logic       din,
    input logic       rst_act,
    input logic       pst_act,
    input logic       state_q,
    input logic       q_o,
    input logic [2:0] oe_sel,
    input logic       oe_o,
    input logic       pullup_o
);
    // R1
    d_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((mode == 2'd0 || mode == 2'd3) && (!clk_edge || !clken) && !rst_act && !pst_act)
        |=> $stable(state_q));

    // R2
    t_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode == 2'd1 && clk_edge && clken && din && !rst_act && !pst_act)
        |=> state_q != $past(state_q));

    // R4
    latch_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode == 2'd2 && clk_lvl && !rst_act && !pst_act)
        |=> state_q == $past(din));

    // R7
    rst_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_act |=> !state_q);

    // R8
    pst_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pst_act && !rst_act) |=> state_q);

    // R8
    rst_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rst_act && pst_act) |-> !q_o);

    // R10
    oe_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (oe_sel == 3'd6) |-> oe_o);

    // R10
    oe_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (oe_sel == 3'd0 || oe_sel == 3'd7) |-> !oe_o);

    // R11
    pullup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (oe_sel == 3'd7) |-> pullup_o);
endmodule

bind mcell_store mcell_store_chk u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode     (cfg_mode_i),
    .clk_lvl  (clk_lvl),
    .clk_edge (clk_edge),
    .clken    (clken_i),
    .din      (din),
    .rst_act  (rst_act),
    .pst_act  (pst_act),
    .state_q  (state_q),
    .q_o      (q_o),
    .oe_sel   (cfg_oe_sel_i),
    .oe_o     (oe_o),
    .pullup_o (pullup_o)
);

// File: tb/mcell_store_bench.sv
module mcell_store_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 18;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = '0;
    logic [3:0] clk_sel = 4'd15;
    logic [2:0] rst_sel = '0, pst_sel = '0, oe_sel = '0;
    logic       din_sel = 1'b0, pin_unused = 1'b1;
    logic [3:0] gclk = '0;
    logic       uclk = 1'b0, urst = 1'b0, upst = 1'b0, uoe = 1'b0;
    logic [7:0] ct = '0;
    logic       clken = 1'b0, lterm = 1'b0, pad = 1'b0;
    logic       q, fb, oe, pu;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcell_store u_mcell_store (
        .clk_i(clk), .rst_ni(rst_n), .cfg_mode_i(mode), .cfg_clk_sel_i(clk_sel),
        .cfg_rst_sel_i(rst_sel), .cfg_pst_sel_i(pst_sel), .cfg_din_sel_i(din_sel),
        .cfg_oe_sel_i(oe_sel), .cfg_pin_unused_i(pin_unused), .gclk_i(gclk),
        .uclk_i(uclk), .urst_i(urst), .upst_i(upst), .uoe_i(uoe), .ct_i(ct),
        .clken_i(clken), .lterm_i(lterm), .pad_i(pad),
        .q_o(q), .fb_o(fb), .oe_o(oe), .pullup_o(pu)
    );

    // fields: mode, clk_sel, pulsed source, din_sel, lterm, pad, clken, expected q
    localparam logic [14:0] VEC [NV] = '{
        {2'd0, 4'd0, 4'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},  // R1 load 1
        {2'd0, 4'd0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},  // R1 R6 load lterm 0
        {2'd0, 4'd0, 4'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},  // R6 pad path
        {2'd0, 4'd4, 4'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},  // R5 unselected pulse
        {2'd0, 4'd4, 4'd4, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},  // R5 universal clock
        {2'd0, 4'd5, 4'd5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},  // R1 clken low holds
        {2'd0, 4'd5, 4'd5, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},  // R5 ct4 clock
        {2'd1, 4'd8, 4'd8, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},  // R2 toggle
        {2'd1, 4'd8, 4'd8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},  // R2 t=0 holds
        {2'd1, 4'd8, 4'd8, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},  // R2 toggle
        {2'd1, 4'd8, 4'd8, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},  // R2 clken low
        {2'd1, 4'd6, 4'd7, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},  // R5 ct6 not selected
        {2'd1, 4'd6, 4'd6, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},  // R5 ct5 toggles
        {2'd1, 4'd2, 4'd2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},  // R6 pad toggle
        {2'd2, 4'd3, 4'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R4 latch ignores clken
        {2'd2, 4'd3, 4'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},  // R4 R3
        {2'd2, 4'd1, 4'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},  // R5 latch unselected
        {2'd3, 4'd9, 4'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}   // R5 no clock code
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive_src(input logic [3:0] idx, input logic v);
        if (idx < 4)       gclk[idx[1:0]] = v;
        else if (idx == 4) uclk = v;
        else if (idx <= 8) ct[idx - 4'd1] = v;
    endtask

    function automatic logic oe_exp(input logic [2:0] c);
        case (c)
            3'd1: return ct[0];
            3'd2: return ct[1];
            3'd3: return ct[2];
            3'd4: return ct[6];
            3'd5: return uoe;
            3'd6: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check("R12 q", q, 1'b0);
        check("R12 fb", fb, 1'b0);
        check("R11 unused input", pu, 1'b1);

        for (int i = 0; i < NV; i++) begin
            logic [14:0] v;
            v = VEC[i];
            @(negedge clk);
            mode = v[14:13]; clk_sel = v[12:9]; din_sel = v[4];
            lterm = v[3]; pad = v[2]; clken = v[1];
            drive_src(v[8:5], 1'b1);
            @(negedge clk);
            drive_src(v[8:5], 1'b0);
            #1;
            check($sformatf("R1/R2/R4/R5/R6 vec %0d", i), q, v[0]);
            check("R9 fb", fb, q);
        end

        // R7 / R8 async overrides, D mode with no clock selected
        @(negedge clk);
        mode = 2'd0; clk_sel = 4'd15; lterm = 1'b0; din_sel = 1'b0;
        rst_sel = 3'd0; urst = 1'b1; ct = 8'hFF;
        #1; check("R7 none selected", q, 1'b1);
        @(negedge clk); #1; check("R7 none selected later", q, 1'b1);
        urst = 1'b0; ct = '0;
        rst_sel = 3'd2;
        @(negedge clk); ct[0] = 1'b1;
        #1; check("R7 async reset", q, 1'b0);
        check("R9 fb reset", fb, 1'b0);
        @(negedge clk); ct[0] = 1'b0;
        @(negedge clk); #1; check("R7 stored cleared", q, 1'b0);
        pst_sel = 3'd1; upst = 1'b1;
        #1; check("R8 async preset", q, 1'b1);
        @(negedge clk); upst = 1'b0;
        @(negedge clk); #1; check("R8 stored set", q, 1'b1);
        rst_sel = 3'd1; urst = 1'b1; upst = 1'b1;
        #1; check("R8 reset wins", q, 1'b0);
        @(negedge clk); urst = 1'b0; upst = 1'b0; rst_sel = 3'd0; pst_sel = 3'd0;
        @(negedge clk); #1; check("R8 after both", q, 1'b0);

        // R3 transparency
        mode = 2'd2; clk_sel = 4'd0; gclk[0] = 1'b1; lterm = 1'b1;
        #1; check("R3 follow 1", q, 1'b1);
        lterm = 1'b0; #1; check("R3 follow 0", q, 1'b0);
        lterm = 1'b1; #1; check("R3 follow 1 again", q, 1'b1);
        @(negedge clk); gclk[0] = 1'b0; lterm = 1'b0;
        #1; check("R3 hold when low", q, 1'b1);
        @(negedge clk); #1; check("R3 hold later", q, 1'b1);

        // R10 / R11 output-enable decode
        for (int p = 0; p < 2; p++) begin
            ct = (p == 0) ? 8'b0100_0101 : 8'b1011_1010;
            uoe = (p == 1);
            pin_unused = (p == 0);
            for (int c = 0; c < 8; c++) begin
                oe_sel = 3'(c);
                #1;
                check($sformatf("R10 code %0d", c), oe, oe_exp(3'(c)));
                check($sformatf("R11 code %0d", c), pu,
                      (c == 7) || (c == 0 && pin_unused));
            end
        end

        done = 1'b1;
        report();
        $finish;
    end
endmodule